// File: doc/BRIEF.md
# Dual-Clock Capture FIFO with Burst Request

This block buffers 16-bit sample words produced in a pixel clock domain and hands them to a host that drains them in its own bus clock domain. Words pushed on the write side are stored in a dual-port memory of 2**ADDR_W entries (1024 by default). The read side pops them in arrival order. Read and write positions cross between the domains as Gray-coded counters through synchronizer chains.

On the read side the block raises an active-high transfer request once enough words are buffered for one burst. A select input picks the burst size: either BURST_WORDS words, or BURST_WORDS*BURST_MULT words (16 or 64 by default). After the host has popped one full burst, the request drops. It comes back only when the fill level reaches the threshold again.

The read side also reports an empty flag and a sticky overflow flag. A push that finds the memory full is dropped. The event is carried into the read domain, where it sets the overflow flag. The flag stays set until the host signals a status read.

Top module: `pix_dma_fifo`

## Requirements
- R1: Words popped on the read side appear on `rd_data` in the order they were pushed. Each accepted pop is answered one read clock later by `rd_valid` high together with the word.
- R2: The buffer holds exactly 2**ADDR_W words. A push arriving while it holds that many is discarded and leaves the stored words unchanged.
- R3: A discarded push sets `ovf_flag` in the read domain within a few read clocks. The flag then stays 1 until a one-cycle `stat_rd` pulse, after which it reads 0 from the next read clock on.
- R4: `empty_flag` is 1 while no word is stored and 0 once a pushed word has crossed into the read domain.
- R5: A pop while the buffer is empty is ignored. `rd_valid` stays 0 and no stored word is consumed.
- R6: `dma_req` rises when the read-side fill level reaches the threshold: BURST_WORDS when `burst_large` is 0, BURST_WORDS*BURST_MULT when `burst_large` is 1. The threshold is taken from `burst_large` at the moment the request rises.
- R7: While `dma_req` is high, the block counts accepted pops. On the pop that completes the burst, `dma_req` goes low at that same read clock edge and stays low for at least one cycle. It rises again only if the fill level is still at or above the threshold.
- R8: After reset the block reads `empty_flag`=1, `ovf_flag`=0, `dma_req`=0 and `rd_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write (pixel) clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_push | input | 1 | Push one word this cycle |
| wr_data | input | DATA_W | Word to push |
| rd_clk | input | 1 | Read (host) clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_pop | input | 1 | Pop one word this cycle |
| rd_data | output | DATA_W | Popped word, valid with rd_valid |
| rd_valid | output | 1 | rd_data carries the word of the previous accepted pop |
| burst_large | input | 1 | 0: burst of BURST_WORDS, 1: burst of BURST_WORDS*BURST_MULT |
| stat_rd | input | 1 | Status read strobe; clears ovf_flag |
| dma_req | output | 1 | Active-high transfer request |
| empty_flag | output | 1 | 1 when no word is stored |
| ovf_flag | output | 1 | Sticky: a push was dropped because the buffer was full |

## Verification
The bench builds the block with ADDR_W=5 (32 words), BURST_WORDS=4 and BURST_MULT=4. With these values the large threshold of 16 words is half the depth, and full and overflow are reached within a few dozen pushes. This makes it practical to sweep every fill level around the small threshold and to step across the large threshold one word at a time. The same settings bring the drop-and-rearm sequence of the request within reach, together with a complete fill, overflow, clear and drain cycle in which the expected words are computed from their push index.

// File: rtl/pix_dma_fifo_pkg.sv
package pix_dma_fifo_pkg;

  typedef enum logic {
    REQ_IDLE   = 1'b0,
    REQ_ACTIVE = 1'b1
  } req_state_t;

  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] from_gray(input logic [31:0] g);
    logic [31:0] b;
    b = g;
    for (int s = 1; s < 32; s = s * 2) begin
      b = b ^ (b >> s);
    end
    return b;
  endfunction

endpackage

// File: rtl/pix_dma_fifo_sync.sv
module pix_dma_fifo_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s > 0) ? s - 1 : 0];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pix_dma_fifo_ram.sv
module pix_dma_fifo_ram #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_clk,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rd_clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pix_dma_fifo_wr.sv
module pix_dma_fifo_wr
  import pix_dma_fifo_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2,
  localparam int PW         = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [PW-1:0]     rgray_async,
  input  logic              ovf_ack_async,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [PW-1:0]     wgray,
  output logic              ovf_tgl
);
  localparam logic [PW-1:0] DEPTH_P = PW'(1 << ADDR_W);

  logic [PW-1:0] wbin, wbin_nx, rgray_s, rbin_s;
  logic          full, drop_evt, ack_s, busy, pend;

  pix_dma_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rptr_sync (
    .clk(clk), .rst(rst), .d(rgray_async), .q(rgray_s)
  );

  pix_dma_fifo_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst(rst), .d(ovf_ack_async), .q(ack_s)
  );

  assign rbin_s   = PW'(from_gray(32'(rgray_s)));
  assign full     = (wbin - rbin_s) == DEPTH_P;
  assign we       = push & ~full;
  assign drop_evt = push & full;
  assign waddr    = wbin[ADDR_W-1:0];
  assign wbin_nx  = wbin + PW'(we);
  assign busy     = ovf_tgl ^ ack_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin    <= '0;
      wgray   <= '0;
      ovf_tgl <= 1'b0;
      pend    <= 1'b0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= PW'(to_gray(32'(wbin_nx)));
      if ((drop_evt | pend) && !busy) begin
        ovf_tgl <= ~ovf_tgl;
        pend    <= 1'b0;
      end else if (drop_evt) begin
        pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pix_dma_fifo_rd.sv
module pix_dma_fifo_rd
  import pix_dma_fifo_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2,
  parameter int BURST_WORDS = 16,
  parameter int BURST_MULT  = 4,
  localparam int PW         = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pop,
  input  logic              stat_rd,
  input  logic              burst_large,
  input  logic [PW-1:0]     wgray_async,
  input  logic              ovf_tgl_async,
  output logic              re,
  output logic [ADDR_W-1:0] raddr,
  output logic [PW-1:0]     rgray,
  output logic              ovf_ack,
  output logic              empty_flag,
  output logic              ovf_flag,
  output logic              dma_req,
  output logic              rd_valid
);
  localparam logic [PW-1:0] THR_SMALL = PW'(BURST_WORDS);
  localparam logic [PW-1:0] THR_LARGE = PW'(BURST_WORDS * BURST_MULT);

  logic [PW-1:0] rbin, rbin_nx, wgray_s, wbin_s, level, thr_sel, thr_q, burst_cnt;
  logic          ovf_req_s, ovf_set;
  req_state_t    req_st;

  pix_dma_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wptr_sync (
    .clk(clk), .rst(rst), .d(wgray_async), .q(wgray_s)
  );

  pix_dma_fifo_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ovf_sync (
    .clk(clk), .rst(rst), .d(ovf_tgl_async), .q(ovf_req_s)
  );

  assign wbin_s  = PW'(from_gray(32'(wgray_s)));
  assign level   = wbin_s - rbin;
  assign re      = pop & (level != '0);
  assign rbin_nx = rbin + PW'(re);
  assign raddr   = rbin[ADDR_W-1:0];
  assign thr_sel = burst_large ? THR_LARGE : THR_SMALL;
  assign ovf_set = ovf_req_s ^ ovf_ack;
  assign dma_req = (req_st == REQ_ACTIVE);

  // pointer, flags
  always_ff @(posedge clk) begin
    if (rst) begin
      rbin       <= '0;
      rgray      <= '0;
      empty_flag <= 1'b1;
      rd_valid   <= 1'b0;
      ovf_ack    <= 1'b0;
      ovf_flag   <= 1'b0;
    end else begin
      rbin       <= rbin_nx;
      rgray      <= PW'(to_gray(32'(rbin_nx)));
      empty_flag <= (rbin_nx == wbin_s);
      rd_valid   <= re;
      ovf_ack    <= ovf_req_s;
      ovf_flag   <= ovf_set | (ovf_flag & ~stat_rd);
    end
  end

  // burst request: rise on threshold, fall after one burst of pops
  always_ff @(posedge clk) begin
    if (rst) begin
      req_st    <= REQ_IDLE;
      thr_q     <= THR_SMALL;
      burst_cnt <= '0;
    end else begin
      case (req_st)
        REQ_IDLE: begin
          if (level >= thr_sel) begin
            req_st    <= REQ_ACTIVE;
            thr_q     <= thr_sel;
            burst_cnt <= '0;
          end
        end
        default: begin
          if (re) begin
            if (burst_cnt == thr_q - PW'(1)) req_st <= REQ_IDLE;
            else burst_cnt <= burst_cnt + PW'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pix_dma_fifo.sv
module pix_dma_fifo #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2,
  parameter int BURST_WORDS = 16,
  parameter int BURST_MULT  = 4
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_push,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              burst_large,
  input  logic              stat_rd,
  output logic              dma_req,
  output logic              empty_flag,
  output logic              ovf_flag
);
  localparam int PW = ADDR_W + 1;

  logic              we, re, ovf_tgl, ovf_ack;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PW-1:0]     wgray, rgray;

  pix_dma_fifo_wr #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_wr (
    .clk(wr_clk), .rst(wr_rst), .push(wr_push),
    .rgray_async(rgray), .ovf_ack_async(ovf_ack),
    .we(we), .waddr(waddr), .wgray(wgray), .ovf_tgl(ovf_tgl)
  );

  pix_dma_fifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .wr_clk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .rd_clk(rd_clk), .re(re), .raddr(raddr), .rdata(rd_data)
  );

  pix_dma_fifo_rd #(
    .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES),
    .BURST_WORDS(BURST_WORDS), .BURST_MULT(BURST_MULT)
  ) u_rd (
    .clk(rd_clk), .rst(rd_rst), .pop(rd_pop), .stat_rd(stat_rd),
    .burst_large(burst_large), .wgray_async(wgray), .ovf_tgl_async(ovf_tgl),
    .re(re), .raddr(raddr), .rgray(rgray), .ovf_ack(ovf_ack),
    .empty_flag(empty_flag), .ovf_flag(ovf_flag), .dma_req(dma_req),
    .rd_valid(rd_valid)
  );
endmodule

// File: rtl/pix_dma_fifo_chk.sv
module pix_dma_fifo_chk (
  input logic rd_clk,
  input logic rd_rst,
  input logic rd_pop,
  input logic rd_valid,
  input logic stat_rd,
  input logic dma_req,
  input logic empty_flag,
  input logic ovf_flag
);
  // R8: values right after reset
  p_reset_state_r8: assert property (@(posedge rd_clk) disable iff (rd_rst)
    $past(rd_rst) |-> (empty_flag && !ovf_flag && !dma_req && !rd_valid));

  // R5 / R1: data strobe only answers a pop
  p_valid_after_pop_r5: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_valid |-> $past(rd_pop));

  // R3: overflow flag is sticky until a status read
  p_ovf_sticky_r3: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (ovf_flag && !stat_rd) |=> ovf_flag);

  // R6: a raised request always has buffered words behind it
  p_req_has_data_r6: assert property (@(posedge rd_clk) disable iff (rd_rst)
    dma_req |-> !empty_flag);

  // R7: request falls only on a pop
  p_req_falls_on_pop_r7: assert property (@(posedge rd_clk) disable iff (rd_rst)
    $fell(dma_req) |-> $past(rd_pop));
endmodule

bind pix_dma_fifo pix_dma_fifo_chk u_chk (
  .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_pop(rd_pop), .rd_valid(rd_valid),
  .stat_rd(stat_rd), .dma_req(dma_req), .empty_flag(empty_flag),
  .ovf_flag(ovf_flag)
);

// File: tb/pix_dma_fifo_test.sv
`timescale 1ns/1ps
module pix_dma_fifo_test;
  localparam int DW    = 16;
  localparam int AW    = 5;
  localparam int DEPTH = 1 << AW;
  localparam int BW    = 4;
  localparam int BM    = 4;

  logic          wr_clk = 0, rd_clk = 0;
  logic          wr_rst = 1, rd_rst = 1;
  logic          wr_push = 0, rd_pop = 0, burst_large = 0, stat_rd = 0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic          rd_valid, dma_req, empty_flag, ovf_flag;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 rd_clk = ~rd_clk;
  always #3.5 wr_clk = ~wr_clk;

  pix_dma_fifo #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2),
                 .BURST_WORDS(BW), .BURST_MULT(BM)) uut (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_push(wr_push), .wr_data(wr_data),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_pop(rd_pop), .rd_data(rd_data),
    .rd_valid(rd_valid), .burst_large(burst_large), .stat_rd(stat_rd),
    .dma_req(dma_req), .empty_flag(empty_flag), .ovf_flag(ovf_flag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push_n(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wr_push = 1;
      wr_data = DW'(base + i);
    end
    @(negedge wr_clk);
    wr_push = 0;
  endtask

  task automatic settle();
    repeat (12) @(negedge wr_clk);
    repeat (12) @(negedge rd_clk);
  endtask

  task automatic pop_one(output logic v, output logic [DW-1:0] d);
    @(negedge rd_clk);
    rd_pop = 1;
    @(negedge rd_clk);
    rd_pop = 0;
    v = rd_valid;
    d = rd_data;
  endtask

  task automatic drain_chk(input int n, input int base, input string tag);
    logic v;
    logic [DW-1:0] d;
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      pop_one(v, d);
      if (!v || d !== DW'(base + i)) begin
        bad++;
        $display("FAIL %s: word %0d actual %0h/%0b expected %0h/1", tag, i, d, v, DW'(base + i));
      end
    end
    tests++;
    if (bad != 0) fails++;
  endtask

  initial begin
    repeat (150000) @(posedge rd_clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic v;
    logic [DW-1:0] d;
    repeat (10) @(negedge rd_clk);
    wr_rst = 0;
    rd_rst = 0;
    @(negedge rd_clk);

    // R8 reset state
    chk("R8 empty", empty_flag, 1);
    chk("R8 ovf", ovf_flag, 0);
    chk("R8 req", dma_req, 0);
    chk("R8 valid", rd_valid, 0);

    // R6/R4/R1 sweep of fill levels around the small threshold
    for (int n = 0; n <= 2 * BW; n++) begin
      push_n(n, 16 * n);
      settle();
      chk($sformatf("R6 small req n=%0d", n), dma_req, (n >= BW) ? 1 : 0);
      chk($sformatf("R4 empty n=%0d", n), empty_flag, (n == 0) ? 1 : 0);
      drain_chk(n, 16 * n, $sformatf("R1 order n=%0d", n));
      settle();
      chk($sformatf("R4 empty after drain n=%0d", n), empty_flag, 1);
      chk($sformatf("R7 req after drain n=%0d", n), dma_req, 0);
    end

    // R6 large threshold, R7 drop at the burst's last pop
    burst_large = 1;
    push_n(BW * BM - 1, 1000);
    settle();
    chk("R6 large below threshold", dma_req, 0);
    push_n(1, 1000 + BW * BM - 1);
    settle();
    chk("R6 large at threshold", dma_req, 1);
    burst_large = 0;
    drain_chk(BW * BM - 1, 1000, "R1 large order");
    chk("R7 held before last pop", dma_req, 1);
    pop_one(v, d);
    chk("R1 large last word", d, DW'(1000 + BW * BM - 1));
    chk("R7 drop on last pop", dma_req, 0);
    settle();
    chk("R7 stays low when drained", dma_req, 0);

    // R7 re-arm with a second burst waiting
    push_n(2 * BW, 2000);
    settle();
    chk("R7 first burst req", dma_req, 1);
    drain_chk(BW, 2000, "R1 rearm first");
    chk("R7 low right after burst", dma_req, 0);
    settle();
    chk("R7 re-asserted", dma_req, 1);
    drain_chk(BW, 2000 + BW, "R1 rearm second");
    settle();
    chk("R7 low after second burst", dma_req, 0);

    // R2/R3 fill, overflow, sticky, clear, drain
    push_n(DEPTH, 3000);
    settle();
    chk("R3 no ovf at exactly full", ovf_flag, 0);
    push_n(3, 5000);
    settle();
    chk("R3 ovf set", ovf_flag, 1);
    repeat (30) @(negedge rd_clk);
    chk("R3 ovf sticky", ovf_flag, 1);
    @(negedge rd_clk);
    stat_rd = 1;
    @(negedge rd_clk);
    stat_rd = 0;
    chk("R3 ovf cleared", ovf_flag, 0);
    repeat (20) @(negedge rd_clk);
    chk("R3 ovf stays clear", ovf_flag, 0);
    drain_chk(DEPTH, 3000, "R2 dropped words absent");
    settle();
    chk("R2 empty after full drain", empty_flag, 1);

    // R5 pop on empty ignored
    pop_one(v, d);
    chk("R5 no valid on empty pop", v, 0);
    chk("R5 still empty", empty_flag, 1);
    push_n(1, 16'hBEEF);
    settle();
    pop_one(v, d);
    chk("R5 next word intact valid", v, 1);
    chk("R5 next word intact data", d, 16'hBEEF);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule